// File: doc/BRIEF.md
# Configurable Left Shifter with Carry

This block is the left-shift unit of a controller datapath. It moves a 16-bit operand, or a 32-bit operand built from a low word and a high word, toward the most significant bit. The distance comes from a 16-bit control word. That same control word also picks what enters the vacated low-order bits. Those bits are filled either with zeros or with copies of the operand's original bit 0. The last bit pushed past the top of the operand is kept in a carry flag, and every other bit that leaves is discarded.

A shift happens only on a clock edge where the execute input is high. The result, the carry and an error flag are registered. A malformed control word, or a distance that is too long for the chosen width, raises the error flag and leaves the result and the carry as they were. The asynchronous active-low reset is released through a two-stage synchronizer, so the registers leave reset two clock edges after the reset input goes high.

Top module: `lshift_carry_unit`

## Requirements
- R1: While reset is held, and after reset is released, `res_lo`, `res_hi`, `carry` and `err` all read 0.
- R2: On an edge where `exec_en` is low, `res_lo`, `res_hi`, `carry` and `err` keep their values, whatever the data and control inputs are.
- R3: Single-word mode is selected with `dbl_sel` = 0. With fill nibble 0 (control bits 11:8) and count n (control bits 7:0, unsigned) in 1..15, `res_lo` becomes `data_lo` shifted left by n with zeros entering at the bottom, and `res_hi` becomes 0.
- R4: A fill nibble of 8 fills the n vacated low-order positions with copies of bit 0 of the original operand. In double-word mode, bit 0 of `data_lo` is used.
- R5: After a legal shift with n ≥ 1, `carry` holds operand bit (W − n). W is 16 in single-word mode and 32 in double-word mode.
- R6: Double-word mode is selected with `dbl_sel` = 1. The operand is {`data_hi`,`data_lo`}, counts 1..31 are legal, and bits leaving the top of `data_lo` enter the bottom of `res_hi`.
- R7: A legal control word with count 0 copies the operand to the result (`res_hi` = 0 in single-word mode), leaves `carry` unchanged and clears `err`.
- R8: A nonzero value in control bits 15:12, or a fill nibble other than 0 or 8, sets `err` to 1 and leaves `res_lo`, `res_hi` and `carry` unchanged.
- R9: A count of 16 or more in single-word mode, or 32 or more in double-word mode, sets `err` to 1 and leaves `res_lo`, `res_hi` and `carry` unchanged.
- R10: Any legal execution sets `err` to 0.
- R11: The outputs take their new values on the first rising edge at which `exec_en` is sampled high, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| exec_en | input | 1 | Perform the shift on this edge |
| dbl_sel | input | 1 | 1 selects the 32-bit operand {data_hi,data_lo} |
| data_lo | input | 16 | Operand low word |
| data_hi | input | 16 | Operand high word (double-word mode only) |
| ctrl_word | input | 16 | [7:0] count, [11:8] fill select, [15:12] must be 0 |
| res_lo | output | 16 | Result low word |
| res_hi | output | 16 | Result high word, 0 after a single-word execution |
| carry | output | 1 | Last bit shifted out |
| err | output | 1 | Illegal control word on the last execution |

## Verification
Every result is due exactly one rising edge after `exec_en` is seen high. That edge updates `res_lo`, `res_hi`, `carry` and `err` together. Each scenario task raises `exec_en` at a falling edge, lets one rising edge pass, drops `exec_en` at the next falling edge, and samples all outputs there. The idle and error scenarios then hold `exec_en` low, or feed a rejected word, for several further edges with different data. This confirms that no later edge moves the values captured earlier.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned CNT_W   = 8;
  localparam int unsigned FILL_W  = 4;
  localparam int unsigned RSVD_W  = CTRL_W - CNT_W - FILL_W;

  typedef enum logic [FILL_W-1:0] {
    FILL_ZERO = 4'h0,
    FILL_LSB  = 4'h8
  } fill_e;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic [FILL_W-1:0] fill;
    logic [CNT_W-1:0]  count;
  } ctrl_t;
endpackage

// File: rtl/lsc_reset_sync.sv
module lsc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lsc_ctrl_decode.sv
module lsc_ctrl_decode
  import lsc_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              dbl_sel,
  output logic [CNT_W-1:0]  count,
  output logic              fill_lsb,
  output logic              zero_cnt,
  output logic              legal
);
  localparam int unsigned DW = 2 * WORD_W;

  ctrl_t ctrl;
  logic  fill_ok;
  logic  rsvd_ok;
  logic  cnt_ok;
  int unsigned limit;

  always_comb begin
    ctrl     = ctrl_t'(ctrl_word);
    count    = ctrl.count;
    fill_lsb = (ctrl.fill == FILL_LSB);
    fill_ok  = (ctrl.fill == FILL_ZERO) || fill_lsb;
    rsvd_ok  = (ctrl.rsvd == '0);
    limit    = dbl_sel ? DW : WORD_W;
    cnt_ok   = (32'(ctrl.count) < limit);
    zero_cnt = (ctrl.count == '0);
    legal    = fill_ok && rsvd_ok && cnt_ok;
  end
endmodule

// File: rtl/lsc_shift_core.sv
module lsc_shift_core
  import lsc_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [WORD_W-1:0] op_lo,
  input  logic [WORD_W-1:0] op_hi,
  input  logic              dbl_sel,
  input  logic [CNT_W-1:0]  count,
  input  logic              fill_lsb,
  output logic [WORD_W-1:0] sh_lo,
  output logic [WORD_W-1:0] sh_hi,
  output logic              sh_carry
);
  localparam int unsigned DW = 2 * WORD_W;

  logic [DW:0]   ext;
  logic [DW:0]   moved;
  logic [DW-1:0] fill_mask;

  always_comb begin
    ext   = {1'b0, (dbl_sel ? op_hi : {WORD_W{1'b0}}), op_lo};
    moved = ext << count;
    if (fill_lsb && op_lo[0]) fill_mask = ~({DW{1'b1}} << count);
    else                      fill_mask = '0;
    sh_lo = moved[WORD_W-1:0] | fill_mask[WORD_W-1:0];
    if (dbl_sel) begin
      sh_hi    = moved[DW-1:WORD_W] | fill_mask[DW-1:WORD_W];
      sh_carry = moved[DW];
    end else begin
      sh_hi    = '0;
      sh_carry = moved[WORD_W];
    end
  end
endmodule

// File: rtl/lsc_result_reg.sv
module lsc_result_reg #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic              legal,
  input  logic              zero_cnt,
  input  logic [WORD_W-1:0] sh_lo,
  input  logic [WORD_W-1:0] sh_hi,
  input  logic              sh_carry,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi,
  output logic              carry,
  output logic              err
);
  logic [WORD_W-1:0] lo_d, hi_d;
  logic              carry_d, err_d;
  logic              upd_data;

  always_comb begin
    upd_data = exec_en && legal;
    lo_d     = res_lo;
    hi_d     = res_hi;
    carry_d  = carry;
    err_d    = err;
    if (exec_en) err_d = !legal;
    if (upd_data) begin
      lo_d = sh_lo;
      hi_d = sh_hi;
      if (!zero_cnt) carry_d = sh_carry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_lo <= '0;
      res_hi <= '0;
      carry  <= 1'b0;
      err    <= 1'b0;
    end else begin
      res_lo <= lo_d;
      res_hi <= hi_d;
      carry  <= carry_d;
      err    <= err_d;
    end
  end
endmodule

// File: rtl/lshift_carry_unit.sv
module lshift_carry_unit
  import lsc_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic              dbl_sel,
  input  logic [WORD_W-1:0] data_lo,
  input  logic [WORD_W-1:0] data_hi,
  input  logic [CTRL_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] res_lo,
  output logic [WORD_W-1:0] res_hi,
  output logic              carry,
  output logic              err
);
  logic              rst_sync_n;
  logic [CNT_W-1:0]  count;
  logic              fill_lsb, zero_cnt, legal;
  logic [WORD_W-1:0] sh_lo, sh_hi;
  logic              sh_carry;

  lsc_reset_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lsc_ctrl_decode #(.WORD_W(WORD_W)) dec_i (
    .ctrl_word(ctrl_word), .dbl_sel(dbl_sel), .count(count),
    .fill_lsb(fill_lsb), .zero_cnt(zero_cnt), .legal(legal)
  );

  lsc_shift_core #(.WORD_W(WORD_W)) core_i (
    .op_lo(data_lo), .op_hi(data_hi), .dbl_sel(dbl_sel), .count(count),
    .fill_lsb(fill_lsb), .sh_lo(sh_lo), .sh_hi(sh_hi), .sh_carry(sh_carry)
  );

  lsc_result_reg #(.WORD_W(WORD_W)) reg_i (
    .clk(clk), .rst_n(rst_sync_n), .exec_en(exec_en), .legal(legal),
    .zero_cnt(zero_cnt), .sh_lo(sh_lo), .sh_hi(sh_hi), .sh_carry(sh_carry),
    .res_lo(res_lo), .res_hi(res_hi), .carry(carry), .err(err)
  );
endmodule

// File: rtl/lsc_checker.sv
module lsc_checker #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              exec_en,
  input logic              dbl_sel,
  input logic [WORD_W-1:0] data_lo,
  input logic [15:0]       ctrl_word,
  input logic [WORD_W-1:0] res_lo,
  input logic [WORD_W-1:0] res_hi,
  input logic              carry,
  input logic              err
);
  logic bad_fmt;
  logic good_single;

  always_comb begin
    bad_fmt     = (ctrl_word[15:12] != 4'h0) ||
                  ((ctrl_word[11:8] != 4'h0) && (ctrl_word[11:8] != 4'h8));
    good_single = !dbl_sel && (ctrl_word[15:12] == 4'h0) &&
                  ((ctrl_word[11:8] == 4'h0) || (ctrl_word[11:8] == 4'h8)) &&
                  (32'(ctrl_word[7:0]) < WORD_W);
  end

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !exec_en |=> ($stable(res_lo) && $stable(res_hi) && $stable(carry) && $stable(err)));

  p_single_hi_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && good_single) |=> (res_hi == '0));

  p_zero_count_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && ctrl_word == 16'h0000) |=>
      (!err && res_lo == $past(data_lo) && $stable(carry)));

  p_bad_fmt_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && bad_fmt) |=> (err && $stable(res_lo) && $stable(res_hi) && $stable(carry)));

  p_range_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && !dbl_sel && 32'(ctrl_word[7:0]) >= WORD_W) |=>
      (err && $stable(res_lo) && $stable(carry)));

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && good_single) |=> !err);
endmodule

bind lshift_carry_unit lsc_checker #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst_sync_n(rst_sync_n), .exec_en(exec_en), .dbl_sel(dbl_sel),
  .data_lo(data_lo), .ctrl_word(ctrl_word), .res_lo(res_lo), .res_hi(res_hi),
  .carry(carry), .err(err)
);

// File: tb/lshift_carry_unit_tb_top.sv
module lshift_carry_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        exec_en;
  logic        dbl_sel;
  logic [15:0] data_lo, data_hi, ctrl_word;
  logic [15:0] res_lo, res_hi;
  logic        carry, err;

  int checks;
  int failures;
  bit done;

  lshift_carry_unit #(.WORD_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .dbl_sel(dbl_sel),
    .data_lo(data_lo), .data_hi(data_hi), .ctrl_word(ctrl_word),
    .res_lo(res_lo), .res_hi(res_hi), .carry(carry), .err(err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state kept by the bench
  logic [15:0] m_lo, m_hi;
  logic        m_c, m_e;

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check({tag, " res_lo"}, 64'(res_lo), 64'(m_lo));
    check({tag, " res_hi"}, 64'(res_hi), 64'(m_hi));
    check({tag, " carry"},  64'(carry),  64'(m_c));
    check({tag, " err"},    64'(err),    64'(m_e));
  endtask

  // bit-serial reference built from the requirements
  task automatic model(input logic [15:0] lo, input logic [15:0] hi,
                       input logic [15:0] cw, input logic dbl);
    int w;
    int n;
    logic [31:0] op;
    logic fb;
    w  = dbl ? 32 : 16;
    n  = int'(cw[7:0]);
    if (cw[15:12] != 0 || (cw[11:8] != 0 && cw[11:8] != 8) || n >= w) begin
      m_e = 1'b1;
      return;
    end
    m_e = 1'b0;
    op  = dbl ? {hi, lo} : {16'h0, lo};
    fb  = (cw[11:8] == 4'h8) ? lo[0] : 1'b0;
    for (int i = 0; i < n; i++) begin
      m_c = op[w-1];
      op  = (op << 1) | 32'(fb);
      if (!dbl) op[31:16] = '0;
    end
    m_lo = op[15:0];
    m_hi = dbl ? op[31:16] : 16'h0;
  endtask

  task automatic run_op(input logic [15:0] lo, input logic [15:0] hi,
                        input logic [15:0] cw, input logic dbl);
    @(negedge clk);
    data_lo = lo; data_hi = hi; ctrl_word = cw; dbl_sel = dbl; exec_en = 1'b1;
    model(lo, hi, cw, dbl);
    @(negedge clk);
    exec_en = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; exec_en = 1'b0; dbl_sel = 1'b0;
    data_lo = 16'hFFFF; data_hi = 16'hFFFF; ctrl_word = 16'h0001;
    m_lo = '0; m_hi = '0; m_c = 1'b0; m_e = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");
  endtask

  task automatic t_single_zero();
    run_op(16'h1234, 16'h0, 16'h0004, 1'b0);
    check_all("R3 0x1234<<4");
    check("R11 R3 direct", 64'(res_lo), 64'h2340);
    run_op(16'hC001, 16'hAAAA, 16'h0001, 1'b0);
    check_all("R3 R5 msb out");
    check("R5 carry 1", 64'(carry), 64'h1);
    run_op(16'h0001, 16'h0, 16'h000F, 1'b0);
    check_all("R3 max count 15");
  endtask

  task automatic t_single_fill();
    run_op(16'h8001, 16'h0, 16'h080A, 1'b0);
    check_all("R4 fill lsb n=10");
    check("R4 direct", 64'({carry, res_lo}), 64'h007FF);
    run_op(16'hFFFE, 16'h0, 16'h0803, 1'b0);
    check_all("R4 fill with lsb 0");
  endtask

  task automatic t_double();
    run_op(16'hF00D, 16'h0001, 16'h0008, 1'b1);
    check_all("R6 cross word");
    check("R6 hi direct", 64'(res_hi), 64'h01F0);
    run_op(16'h0003, 16'h8000, 16'h081F, 1'b1);
    check_all("R6 R4 R5 n=31 fill");
    run_op(16'h1234, 16'h5678, 16'h0010, 1'b1);
    check_all("R6 n=16");
  endtask

  task automatic t_zero_count();
    run_op(16'h8000, 16'h0, 16'h0001, 1'b0);
    run_op(16'hBEEF, 16'hCAFE, 16'h0000, 1'b1);
    m_c = 1'b1; m_lo = 16'hBEEF; m_hi = 16'hCAFE; m_e = 1'b0;
    check_all("R7 count 0 double keeps carry");
    run_op(16'h4321, 16'hCAFE, 16'h0800, 1'b0);
    m_lo = 16'h4321; m_hi = 16'h0; m_e = 1'b0;
    check_all("R7 count 0 single");
  endtask

  task automatic t_bad_ctrl();
    logic [15:0] lo_s, hi_s;
    logic        c_s;
    run_op(16'h00FF, 16'h0, 16'h0009, 1'b0);
    lo_s = m_lo; hi_s = m_hi; c_s = m_c;
    run_op(16'h1111, 16'h2222, 16'h1001, 1'b0);
    m_lo = lo_s; m_hi = hi_s; m_c = c_s; m_e = 1'b1;
    check_all("R8 top nibble");
    run_op(16'h3333, 16'h4444, 16'h0401, 1'b1);
    m_lo = lo_s; m_hi = hi_s; m_c = c_s; m_e = 1'b1;
    check_all("R8 fill code 4");
  endtask

  task automatic t_bad_count();
    logic [15:0] lo_s;
    logic        c_s;
    lo_s = m_lo; c_s = m_c;
    run_op(16'h5555, 16'h0, 16'h0010, 1'b0);
    m_lo = lo_s; m_c = c_s; m_e = 1'b1;
    check_all("R9 single n=16");
    run_op(16'h5555, 16'h6666, 16'h0020, 1'b1);
    m_lo = lo_s; m_c = c_s; m_e = 1'b1;
    check_all("R9 double n=32");
  endtask

  task automatic t_err_clear();
    run_op(16'h0F0F, 16'h0, 16'h0002, 1'b0);
    check("R10 err cleared", 64'(err), 64'h0);
    check_all("R10 result");
  endtask

  task automatic t_idle_hold();
    @(negedge clk);
    data_lo = 16'hDEAD; data_hi = 16'hBEEF; ctrl_word = 16'h0801; dbl_sel = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R2 idle hold");
    ctrl_word = 16'hF0FF;
    repeat (2) @(negedge clk);
    check_all("R2 idle bad ctrl");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset();
    t_single_zero();
    t_single_fill();
    t_double();
    t_zero_count();
    t_bad_ctrl();
    t_bad_count();
    t_err_clear();
    t_idle_hold();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule